// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO Pair

This block moves 36-bit words in both directions between two unrelated clock domains. It holds two independent queues of 64 words each. The forward queue is filled from port A and drained at port B. The return queue is filled from port B and drained at port A. Each port has a single set of controls: an active-low select, a direction bit, a mailbox-select bit and an enable. The decoder in each port uses these controls to pick whether that port pushes into one queue or pops from the other.

Each port keeps the last word it popped in a registered output. The output changes only on a successful pop. Status flags are produced in the clock domain of the port that uses them. An event in the other domain reaches a flag through Gray-coded pointers and a two-stage synchronizer. Port B gets an almost-empty indication for the forward queue, with a programmable threshold, and a full indication for the return queue.

Top module: `bififo_pair`

## Requirements
- R1: While reset is held, and right after it is released, both queues are empty. After reset, `b_empty_n`, `b_ae_n` and `a_empty_n` are 0, and `a_full_n` and `b_full_n` are 1.
- R2: A word on `a_din` enters the forward queue on a rising `clk_a` edge only when `a_cs_n`=0, `a_wr`=1, `a_mb`=0 and `a_en`=1. Any other combination writes nothing.
- R3: On a rising `clk_b` edge with `b_cs_n`=0, `b_wr`=0, `b_mb`=0, `b_en`=1 and a non-empty forward queue, the oldest word is loaded into `b_dout`. It is visible after that edge, and words leave in the order they were written.
- R4: On a rising `clk_b` edge with `b_cs_n`=0, `b_wr`=1, `b_mb`=0 and `b_en`=1, `b_din` is written into the return queue. Port A pops that queue in order into `a_dout` when `a_cs_n`=0, `a_wr`=0, `a_mb`=0 and `a_en`=1.
- R5: `a_dout` and `b_dout` keep their last value through every cycle that has no successful pop, including a pop attempted on an empty queue.
- R6: Each queue holds 64 words. `a_full_n` goes to 0 right after the 64th forward write, and a write attempted while full is dropped without disturbing stored data.
- R7: `b_ae_n` is 0 while the forward queue holds 8 words (parameter) or fewer, and 1 above that. After the write that takes the count from 8 to 9, `b_ae_n` is still 0 after the first `clk_b` edge and is 1 by the third `clk_b` edge. A pop that brings the count back to 8 clears it right after that pop.
- R8: `b_full_n` goes to 0 right after the 64th return-queue write. After one port-A pop from the full queue, it is still 0 after the first `clk_b` edge and is 1 by the third.
- R9: `b_empty_n` goes to 0 right after the pop that takes the last forward word, and `a_empty_n` goes to 0 right after the pop that takes the last return word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_cs_n | input | 1 | Port A select, active low |
| a_wr | input | 1 | Port A direction: 1 writes forward queue, 0 reads return queue |
| a_mb | input | 1 | Port A mailbox select; 1 blocks queue access |
| a_en | input | 1 | Port A enable |
| a_din | input | 36 | Port A write data |
| a_dout | output | 36 | Port A registered read data (return queue) |
| a_full_n | output | 1 | Forward queue not full, `clk_a` domain |
| a_empty_n | output | 1 | Return queue not empty, `clk_a` domain |
| b_cs_n | input | 1 | Port B select, active low |
| b_wr | input | 1 | Port B direction: 1 writes return queue, 0 reads forward queue |
| b_mb | input | 1 | Port B mailbox select; 1 blocks queue access |
| b_en | input | 1 | Port B enable |
| b_din | input | 36 | Port B write data |
| b_dout | output | 36 | Port B registered read data (forward queue) |
| b_empty_n | output | 1 | Forward queue not empty, `clk_b` domain |
| b_ae_n | output | 1 | Forward queue above threshold, `clk_b` domain |
| b_full_n | output | 1 | Return queue not full, `clk_b` domain |

## Verification
Short bursts in each direction show that words come out in order and that the decoders tell push apart from pop. Writes with the mailbox bit set, with the select high, or with the enable low show that only the exact decode moves data. Filling a queue to 64 words and then pushing more separates a correct drop-on-full from an overwrite of the oldest word. Single-word steps across the threshold and out of the full state pin the cross-domain flag latency into a window: the flag must not change after one `clk_b` edge, and must have changed by the third.

// File: rtl/bififo_pkg.sv
package bififo_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_PUSH = 2'd1,
    CMD_POP  = 2'd2
  } port_cmd_e;

  // Shared decode for both ports: select low, mailbox low, enable high,
  // then the direction bit picks push or pop.
  function automatic port_cmd_e decode_port(input logic cs_n, input logic wr,
                                            input logic mb, input logic en);
    if (cs_n || mb || !en) return CMD_IDLE;
    return wr ? CMD_PUSH : CMD_POP;
  endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb stg_d = {stg_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= stg_d;
  end

  assign srst_n = stg_q[1];
endmodule

// File: rtl/gray_sync.sv
module gray_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
    end
  end

  assign dout = s2_q;
endmodule

// File: rtl/fifo_dc.sv
module fifo_dc #(
  parameter int DW     = 36,
  parameter int AW     = 6,
  parameter int AE_LVL = 8
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] wdata,
  output logic          full_n,
  output logic          wr_go,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_req,
  output logic [DW-1:0] rdata,
  output logic          empty_n,
  output logic          ae_n,
  output logic          rd_go
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] AE_CNT   = PW'(AE_LVL);

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // ---------------- write domain ----------------
  logic [PW-1:0] wbin_q, wbin_d, wgray_q, rgray_ws, rbin_ws, wfill;

  gray_sync #(.W(PW)) u_rsync (.clk(wclk), .rst_n(wrst_n), .din(rgray_q), .dout(rgray_ws));

  always_comb begin
    rbin_ws = gray2bin(rgray_ws);
    wfill   = wbin_q - rbin_ws;
    full_n  = (wfill != FULL_CNT);
    wr_go   = wr_req && full_n;
    wbin_d  = wr_go ? wbin_q + 1'b1 : wbin_q;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= bin2gray(wbin_d);
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_go) mem[wbin_q[AW-1:0]] <= wdata;
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, wgray_rs, wbin_rs, rfill;
  logic [DW-1:0] rdata_q, rdata_d;

  gray_sync #(.W(PW)) u_wsync (.clk(rclk), .rst_n(rrst_n), .din(wgray_q), .dout(wgray_rs));

  always_comb begin
    wbin_rs = gray2bin(wgray_rs);
    rfill   = wbin_rs - rbin_q;
    empty_n = (rfill != '0);
    ae_n    = (rfill > AE_CNT);
    rd_go   = rd_req && empty_n;
    rbin_d  = rd_go ? rbin_q + 1'b1 : rbin_q;
    rdata_d = rd_go ? mem[rbin_q[AW-1:0]] : rdata_q;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      rdata_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= bin2gray(rbin_d);
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/bififo_pair.sv
module bififo_pair
  import bififo_pkg::*;
#(
  parameter int DW     = 36,
  parameter int AW     = 6,
  parameter int AE_LVL = 8
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst_n,
  input  logic          a_cs_n,
  input  logic          a_wr,
  input  logic          a_mb,
  input  logic          a_en,
  input  logic [DW-1:0] a_din,
  output logic [DW-1:0] a_dout,
  output logic          a_full_n,
  output logic          a_empty_n,
  input  logic          b_cs_n,
  input  logic          b_wr,
  input  logic          b_mb,
  input  logic          b_en,
  input  logic [DW-1:0] b_din,
  output logic [DW-1:0] b_dout,
  output logic          b_empty_n,
  output logic          b_ae_n,
  output logic          b_full_n
);
  logic rst_a_n, rst_b_n;
  port_cmd_e cmd_a, cmd_b;
  logic f1_wr, f1_rd, f2_wr, f2_rd;
  logic f1_ae_unused_n;
  logic f2_ae_unused_n;

  rst_sync u_rsa (.clk(clk_a), .arst_n(rst_n), .srst_n(rst_a_n));
  rst_sync u_rsb (.clk(clk_b), .arst_n(rst_n), .srst_n(rst_b_n));

  always_comb begin
    cmd_a = decode_port(a_cs_n, a_wr, a_mb, a_en);
    cmd_b = decode_port(b_cs_n, b_wr, b_mb, b_en);
  end

  // Forward queue: port A pushes, port B pops (R2, R3, R7)
  fifo_dc #(.DW(DW), .AW(AW), .AE_LVL(AE_LVL)) u_fwd (
    .wclk(clk_a), .wrst_n(rst_a_n), .wr_req(cmd_a == CMD_PUSH), .wdata(a_din),
    .full_n(a_full_n), .wr_go(f1_wr),
    .rclk(clk_b), .rrst_n(rst_b_n), .rd_req(cmd_b == CMD_POP), .rdata(b_dout),
    .empty_n(b_empty_n), .ae_n(b_ae_n), .rd_go(f1_rd)
  );

  // Return queue: port B pushes, port A pops (R4, R8)
  fifo_dc #(.DW(DW), .AW(AW), .AE_LVL(AE_LVL)) u_ret (
    .wclk(clk_b), .wrst_n(rst_b_n), .wr_req(cmd_b == CMD_PUSH), .wdata(b_din),
    .full_n(b_full_n), .wr_go(f2_wr),
    .rclk(clk_a), .rrst_n(rst_a_n), .rd_req(cmd_a == CMD_POP), .rdata(a_dout),
    .empty_n(a_empty_n), .ae_n(f2_ae_unused_n), .rd_go(f2_rd)
  );

  assign f1_ae_unused_n = f2_ae_unused_n;
endmodule

// File: rtl/bififo_pair_chk.sv
module bififo_pair_chk #(
  parameter int DW = 36
) (
  input logic          clk_a,
  input logic          clk_b,
  input logic          rst_a_n,
  input logic          rst_b_n,
  input logic [DW-1:0] a_dout,
  input logic [DW-1:0] b_dout,
  input logic          a_full_n,
  input logic          b_empty_n,
  input logic          b_ae_n,
  input logic          b_full_n,
  input logic          f1_wr,
  input logic          f1_rd,
  input logic          f2_wr,
  input logic          f2_rd
);
  p_adout_hold_r5: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !f2_rd |=> $stable(a_dout));

  p_bdout_hold_r5: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    !f1_rd |=> $stable(b_dout));

  p_full_after_write_r6: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    $fell(a_full_n) |-> $past(f1_wr));

  p_ae_drop_on_read_r7: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    $fell(b_ae_n) |-> $past(f1_rd));

  p_ae_needs_data_r7: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    b_ae_n |-> b_empty_n);

  p_ret_full_after_write_r8: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    $fell(b_full_n) |-> $past(f2_wr));

  p_empty_after_read_r9: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    $fell(b_empty_n) |-> $past(f1_rd));
endmodule

bind bififo_pair bififo_pair_chk #(.DW(DW)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n),
  .a_dout(a_dout), .b_dout(b_dout), .a_full_n(a_full_n),
  .b_empty_n(b_empty_n), .b_ae_n(b_ae_n), .b_full_n(b_full_n),
  .f1_wr(f1_wr), .f1_rd(f1_rd), .f2_wr(f2_wr), .f2_rd(f2_rd)
);

// File: tb/bififo_pair_tb.sv
`timescale 1ns/1ps
module bififo_pair_tb;
  logic clk_a = 0, clk_b = 0, rst_n = 0;
  logic a_cs_n = 1, a_wr = 0, a_mb = 0, a_en = 0;
  logic b_cs_n = 1, b_wr = 0, b_mb = 0, b_en = 0;
  logic [35:0] a_din = '0, b_din = '0;
  logic [35:0] a_dout, b_dout;
  logic a_full_n, a_empty_n, b_empty_n, b_ae_n, b_full_n;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [35:0] q1[$];
  logic [35:0] q2[$];

  always #10 clk_a = ~clk_a;           // 50 MHz
  initial begin #4; forever #13 clk_b = ~clk_b; end

  bififo_pair u_dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .a_cs_n(a_cs_n), .a_wr(a_wr), .a_mb(a_mb), .a_en(a_en), .a_din(a_din),
    .a_dout(a_dout), .a_full_n(a_full_n), .a_empty_n(a_empty_n),
    .b_cs_n(b_cs_n), .b_wr(b_wr), .b_mb(b_mb), .b_en(b_en), .b_din(b_din),
    .b_dout(b_dout), .b_empty_n(b_empty_n), .b_ae_n(b_ae_n), .b_full_n(b_full_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [35:0] act,
                     input logic [35:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- monitors (scoreboard pop side) ----------------
  logic b_chk = 0, b_ign = 0, a_chk = 0, a_ign = 0;
  logic [35:0] b_hold = '0, a_hold = '0;

  always @(posedge clk_b) begin
    b_chk  <= rst_n && !b_cs_n && !b_wr && !b_mb && b_en && b_empty_n;
    b_ign  <= rst_n && !(!b_cs_n && !b_wr && !b_mb && b_en && b_empty_n);
    b_hold <= b_dout;
  end

  always @(negedge clk_b) begin
    if (b_chk) begin
      if (q1.size() == 0) chk(0, "R3 unexpected forward word", b_dout, '0);
      else begin
        logic [35:0] e;
        e = q1.pop_front();
        chk(b_dout == e, "R3 forward order", b_dout, e);
      end
    end
    if (b_ign) chk(b_dout == b_hold, "R5 b_dout hold", b_dout, b_hold);
  end

  always @(posedge clk_a) begin
    a_chk  <= rst_n && !a_cs_n && !a_wr && !a_mb && a_en && a_empty_n;
    a_ign  <= rst_n && !(!a_cs_n && !a_wr && !a_mb && a_en && a_empty_n);
    a_hold <= a_dout;
  end

  always @(negedge clk_a) begin
    if (a_chk) begin
      if (q2.size() == 0) chk(0, "R4 unexpected return word", a_dout, '0);
      else begin
        logic [35:0] e;
        e = q2.pop_front();
        chk(a_dout == e, "R4 return order", a_dout, e);
      end
    end
    if (a_ign) chk(a_dout == a_hold, "R5 a_dout hold", a_dout, a_hold);
  end

  // ---------------- drivers (scoreboard push side) ----------------
  task automatic wr_a(input logic [35:0] d, input logic cs_n = 0,
                      input logic mb = 0, input logic en = 1);
    @(negedge clk_a);
    a_cs_n = cs_n; a_wr = 1; a_mb = mb; a_en = en; a_din = d;
    if (!cs_n && !mb && en && a_full_n) q1.push_back(d);
    @(posedge clk_a); #2;
    a_en = 0; a_cs_n = 1;
  endtask

  task automatic wr_b(input logic [35:0] d);
    @(negedge clk_b);
    b_cs_n = 0; b_wr = 1; b_mb = 0; b_en = 1; b_din = d;
    if (b_full_n) q2.push_back(d);
    @(posedge clk_b); #2;
    b_en = 0; b_cs_n = 1; b_wr = 0;
  endtask

  task automatic rd_b();
    @(negedge clk_b);
    b_cs_n = 0; b_wr = 0; b_mb = 0; b_en = 1;
    @(posedge clk_b); #2;
    b_en = 0; b_cs_n = 1;
  endtask

  task automatic rd_a();
    @(negedge clk_a);
    a_cs_n = 0; a_wr = 0; a_mb = 0; a_en = 1;
    @(posedge clk_a); #2;
    a_en = 0; a_cs_n = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_b);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    chk(0, "watchdog expired", '0, '0);
    finish_run();
  end

  initial begin
    #100 rst_n = 1;
    repeat (10) @(negedge clk_a);
    idle(4);
    // R1 reset state
    chk(b_empty_n == 0, "R1 b_empty_n", 36'(b_empty_n), 0);
    chk(b_ae_n == 0,    "R1 b_ae_n",    36'(b_ae_n), 0);
    chk(a_empty_n == 0, "R1 a_empty_n", 36'(a_empty_n), 0);
    chk(a_full_n == 1,  "R1 a_full_n",  36'(a_full_n), 1);
    chk(b_full_n == 1,  "R1 b_full_n",  36'(b_full_n), 1);
    chk(b_dout == 0,    "R1 b_dout",    b_dout, 0);

    // R2 writes with wrong decode are ignored
    wr_a(36'h111, 0, 1, 1);
    wr_a(36'h222, 1, 0, 1);
    wr_a(36'h333, 0, 0, 0);
    idle(6);
    chk(b_empty_n == 0, "R2 decode blocked writes", 36'(b_empty_n), 0);

    // R2/R3 short burst
    for (int i = 0; i < 5; i++) wr_a(36'hA_0000_0000 + 36'(i * 7));
    idle(6);
    chk(b_empty_n == 1, "R2 forward has data", 36'(b_empty_n), 1);
    for (int i = 0; i < 5; i++) rd_b();
    idle(1);
    chk(b_empty_n == 0, "R9 forward empty after last pop", 36'(b_empty_n), 0);
    rd_b();                               // R5 pop on empty: monitor checks hold
    idle(2);

    // R7 threshold crossing and latency
    for (int i = 0; i < 8; i++) wr_a(36'h5_0000_0000 | 36'(i));
    idle(6);
    chk(b_ae_n == 0, "R7 b_ae_n low at threshold", 36'(b_ae_n), 0);
    @(negedge clk_a);
    a_cs_n = 0; a_wr = 1; a_mb = 0; a_en = 1; a_din = 36'h5_0000_0008;
    q1.push_back(a_din);
    @(posedge clk_a); #2; a_en = 0; a_cs_n = 1;
    @(posedge clk_b); @(negedge clk_b);
    chk(b_ae_n == 0, "R7 b_ae_n not early", 36'(b_ae_n), 0);
    @(posedge clk_b); @(posedge clk_b); @(negedge clk_b);
    chk(b_ae_n == 1, "R7 b_ae_n by third edge", 36'(b_ae_n), 1);
    rd_b();
    @(negedge clk_b);
    chk(b_ae_n == 0, "R7 b_ae_n clears on pop to 8", 36'(b_ae_n), 0);
    for (int i = 0; i < 8; i++) rd_b();
    idle(10);

    // R6 fill forward queue, overflow dropped
    for (int i = 0; i < 64; i++) wr_a(36'hC_0000_0000 + 36'(i * 3));
    @(negedge clk_a);
    chk(a_full_n == 0, "R6 a_full_n at 64", 36'(a_full_n), 0);
    wr_a(36'hDEAD);
    wr_a(36'hBEEF);
    chk(q1.size() == 64, "R6 overflow not queued", 36'(q1.size()), 64);
    idle(4);
    for (int i = 0; i < 64; i++) rd_b();
    idle(4);
    chk(b_empty_n == 0, "R6 no extra word after drain", 36'(b_empty_n), 0);
    chk(q1.size() == 0, "R6 all forward words seen", 36'(q1.size()), 0);

    // R4/R8 return queue fill and full-flag release latency
    for (int i = 0; i < 64; i++) wr_b(36'h7_0000_0000 ^ 36'(i * 11));
    @(negedge clk_b);
    chk(b_full_n == 0, "R8 b_full_n at 64", 36'(b_full_n), 0);
    wr_b(36'hFFFF);
    chk(q2.size() == 64, "R6 return overflow not queued", 36'(q2.size()), 64);
    repeat (6) @(negedge clk_a);
    chk(a_empty_n == 1, "R4 return has data", 36'(a_empty_n), 1);
    rd_a();
    @(posedge clk_b); @(negedge clk_b);
    chk(b_full_n == 0, "R8 b_full_n not early", 36'(b_full_n), 0);
    @(posedge clk_b); @(posedge clk_b); @(negedge clk_b);
    chk(b_full_n == 1, "R8 b_full_n by third edge", 36'(b_full_n), 1);
    for (int i = 0; i < 63; i++) rd_a();
    @(negedge clk_a);
    chk(a_empty_n == 0, "R9 return empty after last pop", 36'(a_empty_n), 0);
    rd_a();                               // R5 pop on empty at port A
    repeat (3) @(negedge clk_a);
    chk(q2.size() == 0, "R4 all return words seen", 36'(q2.size()), 0);

    finish_run();
  end
endmodule